// File: doc/BRIEF.md
# Per-Channel DMA Control and Status Register Bank

This block is the software-visible control and status store for a multi-channel DMA engine of up to 64 channels. Each per-channel property (hardware request enable, error interrupt enable, interrupt pending, error pending, completion status and hardware request status) is one bit of a channel-wide vector. The vector is read and written as a low word (channels 31..0) and a high word (channels 63..32). Software can also change one channel's bit on its own by writing that channel's number to a command register, with no read-modify-write of the word.

The transfer engine reports completions through a per-channel event vector and reports errors with a channel number and a cause mask. The first error is captured in a status word, together with its channel index and its cause bits. It stays there until software clears the error of that channel. A single level interrupt output summarises every pending completion and every enabled pending error. The block also holds the arbitration control bits and a per-channel priority byte, and drives them to the engine.

The register port is a plain single-cycle port. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` follows `reg_addr` combinationally. There is no back-pressure. Offsets not listed below read as zero and ignore writes.

Top module: `dmareg_bank`

## Requirements
- R1: After reset every vector, the control word and the error status word read zero, `irq` is low and `start_pulse` is zero.
- R2: Word offsets are: control 0x000, error status 0x004, request enable high/low 0x008/0x00C, error interrupt enable high/low 0x010/0x014, interrupt pending high/low 0x020/0x024, error pending high/low 0x028/0x02C, hardware request status high/low 0x030/0x034, completion high/low 0x038/0x03C. Channel c sits at bit c of the low word, or at bit c-32 of the high word. A plain write to a request enable word or an error interrupt enable word replaces the bits of that word.
- R3: Command registers are at word offsets 0x040 + 4*k. The channel number is in write data bits 7:0. The commands are: k=0 set request enable, k=1 clear request enable, k=2 set error interrupt enable, k=3 clear error interrupt enable, k=4 clear interrupt pending, k=5 clear error pending, k=6 start, k=7 clear completion. Each command changes only the bit of the named channel.
- R4: A command whose channel number is NCH or above changes no state and produces no start pulse.
- R5: A bit of `done_evt` sets both the interrupt pending bit and the completion bit of its channel, from the next cycle on.
- R6: Writing to an interrupt pending word or an error pending word clears each bit written as one and leaves every bit written as zero. All ones clears the whole word.
- R7: An `err_evt` with `err_chan` below NCH sets that channel's error pending bit. When no error is latched, it also loads the error status word: bit 31 valid, bits 13:8 the channel, and bits 15, 14 and 7..0 copied from `err_cause`. Every other bit reads zero.
- R8: While the valid bit is set, later errors leave the status word unchanged. Clearing the error pending bit of the latched channel, by command or by word write, empties the word to zero. If a new error arrives in that same cycle, the new error is captured instead.
- R9: `irq` is high whenever any interrupt pending bit is set, or any error pending bit is set whose error interrupt enable is also set.
- R10: A start command for channel c makes `start_pulse[c]` high for exactly the one cycle after the write.
- R11: In the control word only bits 31, 3 and 2 are stored. They drive `ctrl_clkgate`, `rr_group` and `rr_chan`, and all other bits read zero.
- R12: Priority bytes are at offset 0x100 + c, four per word, with channel 4w+j in byte j of word w. They are readable, writable, and driven on `chan_prio[8c+7:8c]`.
- R13: When an event set and a clear of the same bit fall in the same cycle, the bit ends set.
- R14: The hardware request status words read back the `hwreq_in` vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| done_evt | input | NCH | Per-channel completion event pulse |
| err_evt | input | 1 | Error event pulse from the engine |
| err_chan | input | 6 | Channel of the error event |
| err_cause | input | 16 | Cause mask of the error event |
| hwreq_in | input | NCH | Live hardware request lines |
| req_en | output | NCH | Hardware request enable per channel |
| start_pulse | output | NCH | One-cycle software start per channel |
| chan_prio | output | NCH*8 | Priority byte per channel |
| ctrl_clkgate | output | 1 | Dynamic clock gating enable |
| rr_group | output | 1 | Round-robin group arbitration |
| rr_chan | output | 1 | Round-robin channel arbitration |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of functions can land on the same edge. The first pair is a completion event and a software clear of that same channel's interrupt pending bit. The second pair is an error event and a clear of the error of the channel that is already latched. The bench drives each pair together in one low clock phase: the event pin and the command write. It judges the first pair by reading back the interrupt pending word, where the bit must survive. It judges the second pair by reading the error status word, which must carry the new channel and cause rather than zero.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int ADDR_W  = 12;
  localparam int NUM_OPS = 8;

  localparam logic [ADDR_W-1:0] A_CTRL     = 12'h000;
  localparam logic [ADDR_W-1:0] A_ESTAT    = 12'h004;
  localparam logic [ADDR_W-1:0] A_REQ_HI   = 12'h008;
  localparam logic [ADDR_W-1:0] A_REQ_LO   = 12'h00C;
  localparam logic [ADDR_W-1:0] A_EEI_HI   = 12'h010;
  localparam logic [ADDR_W-1:0] A_EEI_LO   = 12'h014;
  localparam logic [ADDR_W-1:0] A_INT_HI   = 12'h020;
  localparam logic [ADDR_W-1:0] A_INT_LO   = 12'h024;
  localparam logic [ADDR_W-1:0] A_ERR_HI   = 12'h028;
  localparam logic [ADDR_W-1:0] A_ERR_LO   = 12'h02C;
  localparam logic [ADDR_W-1:0] A_HRS_HI   = 12'h030;
  localparam logic [ADDR_W-1:0] A_HRS_LO   = 12'h034;
  localparam logic [ADDR_W-1:0] A_DONE_HI  = 12'h038;
  localparam logic [ADDR_W-1:0] A_DONE_LO  = 12'h03C;
  localparam logic [ADDR_W-1:0] A_CMD_BASE = 12'h040;
  localparam logic [ADDR_W-1:0] A_PRIO_BASE = 12'h100;

  // control word: clock gating bit 31, group round robin bit 3, channel round robin bit 2
  localparam int CTRL_CG_BIT  = 31;
  localparam int CTRL_RRG_BIT = 3;
  localparam int CTRL_RRC_BIT = 2;
  localparam logic [31:0] CTRL_MASK = 32'h8000_000C;

  // error status: valid 31, channel 13:8, causes 15,14,7..0
  localparam logic [31:0] ESTAT_CAUSE_MASK = 32'h0000_C0FF;
  localparam int ESTAT_VALID_BIT = 31;
  localparam int ESTAT_CH_LSB    = 8;

  typedef enum logic [2:0] {
    OP_SET_REQ  = 3'd0,
    OP_CLR_REQ  = 3'd1,
    OP_SET_EEI  = 3'd2,
    OP_CLR_EEI  = 3'd3,
    OP_CLR_INT  = 3'd4,
    OP_CLR_ERR  = 3'd5,
    OP_START    = 3'd6,
    OP_CLR_DONE = 3'd7
  } cmd_op_e;
endpackage

// File: rtl/dmareg_cmd_dec.sv
module dmareg_cmd_dec import dmareg_pkg::*; #(
  parameter int NCH = 64
) (
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [7:0]                    chan,
  output logic [NUM_OPS-1:0][NCH-1:0]   op_vec
);
  localparam int OP_W = $clog2(NUM_OPS);

  logic [63:0]    sel64;
  logic [NCH-1:0] sel;
  logic           is_cmd;

  // channel one-hot; a number at or above NCH selects nothing (R4)
  always_comb begin
    sel64 = 64'd1 << chan[5:0];
    sel   = (32'(chan) < NCH) ? sel64[NCH-1:0] : '0;
  end

  assign is_cmd = wr && (addr[ADDR_W-1:5] == A_CMD_BASE[ADDR_W-1:5]) && (addr[1:0] == 2'b00);

  genvar k;
  generate
    for (k = 0; k < NUM_OPS; k++) begin : g_op
      assign op_vec[k] = (is_cmd && addr[2+:OP_W] == OP_W'(k)) ? sel : '0;
    end
  endgenerate
endmodule

// File: rtl/dmareg_chvec.sv
module dmareg_chvec #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] q
);
  // set has priority over a clear in the same cycle (R13)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_v) | set_v;
  end
endmodule

// File: rtl/dmareg_errlatch.sv
module dmareg_errlatch import dmareg_pkg::*; #(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt,
  input  logic [5:0]     chan,
  input  logic [15:0]    cause,
  input  logic [NCH-1:0] clr_v,
  output logic [31:0]    stat
);
  logic [63:0] clr64;
  logic        evt_ok;
  logic        release_now;

  assign clr64       = 64'(clr_v);
  assign evt_ok      = evt && (32'(chan) < NCH);
  assign release_now = stat[ESTAT_VALID_BIT] && clr64[stat[ESTAT_CH_LSB+:6]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else if (evt_ok && (!stat[ESTAT_VALID_BIT] || release_now)) begin
      stat <= (32'd1 << ESTAT_VALID_BIT) | (32'(cause) & ESTAT_CAUSE_MASK)
              | (32'(chan) << ESTAT_CH_LSB);
    end else if (release_now) begin
      stat <= '0;
    end
  end
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank import dmareg_pkg::*; #(
  parameter int NCH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    done_evt,
  input  logic              err_evt,
  input  logic [5:0]        err_chan,
  input  logic [15:0]       err_cause,
  input  logic [NCH-1:0]    hwreq_in,
  output logic [NCH-1:0]    req_en,
  output logic [NCH-1:0]    start_pulse,
  output logic [NCH*8-1:0]  chan_prio,
  output logic              ctrl_clkgate,
  output logic              rr_group,
  output logic              rr_chan,
  output logic              irq
);
  localparam int PAD_W  = 64;
  localparam int PRIO_W = PAD_W * 8;

  function automatic logic [NCH-1:0] lane(input logic hi, input logic [31:0] d);
    logic [PAD_W-1:0] w;
    w = hi ? {d, 32'h0} : {32'h0, d};
    return w[NCH-1:0];
  endfunction

  logic [NUM_OPS-1:0][NCH-1:0] op_vec;
  logic [NCH-1:0] req_set, req_clr, eei_set, eei_clr;
  logic [NCH-1:0] int_clr, err_set, err_clr, done_clr;
  logic [NCH-1:0] eei_q, int_q, err_q, done_q;
  logic [31:0]    estat;
  logic [31:0]    ctrl_q;
  logic [PAD_W-1:0] err_one;

  dmareg_cmd_dec #(.NCH(NCH)) u_dec (
    .wr(reg_wr), .addr(reg_addr), .chan(reg_wdata[7:0]), .op_vec(op_vec)
  );

  // set and clear sources: commands plus word writes
  always_comb begin
    req_set  = op_vec[OP_SET_REQ];
    req_clr  = op_vec[OP_CLR_REQ];
    eei_set  = op_vec[OP_SET_EEI];
    eei_clr  = op_vec[OP_CLR_EEI];
    int_clr  = op_vec[OP_CLR_INT];
    err_clr  = op_vec[OP_CLR_ERR];
    done_clr = op_vec[OP_CLR_DONE];
    if (reg_wr) begin
      unique case (reg_addr)
        A_REQ_HI: begin req_set |= lane(1'b1, reg_wdata); req_clr |= lane(1'b1, ~reg_wdata); end
        A_REQ_LO: begin req_set |= lane(1'b0, reg_wdata); req_clr |= lane(1'b0, ~reg_wdata); end
        A_EEI_HI: begin eei_set |= lane(1'b1, reg_wdata); eei_clr |= lane(1'b1, ~reg_wdata); end
        A_EEI_LO: begin eei_set |= lane(1'b0, reg_wdata); eei_clr |= lane(1'b0, ~reg_wdata); end
        A_INT_HI: int_clr |= lane(1'b1, reg_wdata);
        A_INT_LO: int_clr |= lane(1'b0, reg_wdata);
        A_ERR_HI: err_clr |= lane(1'b1, reg_wdata);
        A_ERR_LO: err_clr |= lane(1'b0, reg_wdata);
        default: ;
      endcase
    end
    err_one = 64'd1 << err_chan;
    err_set = (err_evt && (32'(err_chan) < NCH)) ? err_one[NCH-1:0] : '0;
  end

  dmareg_chvec #(.N(NCH)) u_req  (.clk(clk), .rst_n(rst_n), .set_v(req_set),  .clr_v(req_clr),  .q(req_en));
  dmareg_chvec #(.N(NCH)) u_eei  (.clk(clk), .rst_n(rst_n), .set_v(eei_set),  .clr_v(eei_clr),  .q(eei_q));
  dmareg_chvec #(.N(NCH)) u_int  (.clk(clk), .rst_n(rst_n), .set_v(done_evt), .clr_v(int_clr),  .q(int_q));
  dmareg_chvec #(.N(NCH)) u_err  (.clk(clk), .rst_n(rst_n), .set_v(err_set),  .clr_v(err_clr),  .q(err_q));
  dmareg_chvec #(.N(NCH)) u_done (.clk(clk), .rst_n(rst_n), .set_v(done_evt), .clr_v(done_clr), .q(done_q));

  dmareg_errlatch #(.NCH(NCH)) u_elat (
    .clk(clk), .rst_n(rst_n), .evt(err_evt), .chan(err_chan),
    .cause(err_cause), .clr_v(err_clr), .stat(estat)
  );

  // start strobes last one cycle (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_pulse <= '0;
    else        start_pulse <= op_vec[OP_START];
  end

  // control word (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (reg_wr && reg_addr == A_CTRL)  ctrl_q <= reg_wdata & CTRL_MASK;
  end
  assign ctrl_clkgate = ctrl_q[CTRL_CG_BIT];
  assign rr_group     = ctrl_q[CTRL_RRG_BIT];
  assign rr_chan      = ctrl_q[CTRL_RRC_BIT];

  // priority bytes (R12)
  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_prio
      logic [7:0] prio_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prio_q <= '0;
        else if (reg_wr && reg_addr[11:6] == A_PRIO_BASE[11:6] && reg_addr[5:2] == 4'(c / 4))
          prio_q <= reg_wdata[8*(c%4) +: 8];
      end
      assign chan_prio[8*c +: 8] = prio_q;
    end
  endgenerate

  assign irq = (|int_q) || (|(err_q & eei_q));

  // read mux
  logic [PAD_W-1:0]  req64, eei64, int64, err64, hrs64, done64;
  logic [PRIO_W-1:0] prio_pad;
  always_comb begin
    req64    = 64'(req_en);
    eei64    = 64'(eei_q);
    int64    = 64'(int_q);
    err64    = 64'(err_q);
    hrs64    = 64'(hwreq_in);
    done64   = 64'(done_q);
    prio_pad = PRIO_W'(chan_prio);
    reg_rdata = '0;
    if (reg_addr[11:6] == A_PRIO_BASE[11:6]) begin
      reg_rdata = prio_pad[{reg_addr[5:2], 5'd0} +: 32];
    end else begin
      unique case (reg_addr)
        A_CTRL:    reg_rdata = ctrl_q;
        A_ESTAT:   reg_rdata = estat;
        A_REQ_HI:  reg_rdata = req64[63:32];
        A_REQ_LO:  reg_rdata = req64[31:0];
        A_EEI_HI:  reg_rdata = eei64[63:32];
        A_EEI_LO:  reg_rdata = eei64[31:0];
        A_INT_HI:  reg_rdata = int64[63:32];
        A_INT_LO:  reg_rdata = int64[31:0];
        A_ERR_HI:  reg_rdata = err64[63:32];
        A_ERR_LO:  reg_rdata = err64[31:0];
        A_HRS_HI:  reg_rdata = hrs64[63:32];
        A_HRS_LO:  reg_rdata = hrs64[31:0];
        A_DONE_HI: reg_rdata = done64[63:32];
        A_DONE_LO: reg_rdata = done64[31:0];
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmareg_bank_chk.sv
module dmareg_bank_chk import dmareg_pkg::*; #(
  parameter int NCH = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [11:0]    reg_addr,
  input logic [31:0]    reg_wdata,
  input logic [NCH-1:0] done_evt,
  input logic           err_evt,
  input logic [5:0]     err_chan,
  input logic [NCH-1:0] start_pulse,
  input logic [NCH-1:0] req_en,
  input logic           rr_chan,
  input logic           irq,
  input logic [31:0]    estat,
  input logic [NCH-1:0] err_clr
);
  logic [63:0] clr64;
  logic        cmd_wr;
  assign clr64  = 64'(err_clr);
  assign cmd_wr = reg_wr && reg_addr[11:5] == A_CMD_BASE[11:5] && reg_addr[1:0] == 2'b00;

  assert_bad_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && 32'(reg_wdata[7:0]) >= NCH) |=> (start_pulse == '0 && $stable(req_en)));

  assert_start_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse));

  assert_done_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |=> irq);

  assert_err_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && 32'(err_chan) < NCH && !estat[31]) |=> (estat[31] && estat[13:8] == $past(err_chan)));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (estat[31] && !clr64[estat[13:8]]) |=> $stable(estat));

  assert_ctrl_rrc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL) |=> (rr_chan == $past(reg_wdata[2])));
endmodule

bind dmareg_bank dmareg_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .done_evt(done_evt), .err_evt(err_evt),
  .err_chan(err_chan), .start_pulse(start_pulse), .req_en(req_en),
  .rr_chan(rr_chan), .irq(irq), .estat(estat), .err_clr(err_clr)
);

// File: tb/dmareg_bank_tb_top.sv
`timescale 1ns/100ps
module dmareg_bank_tb_top;
  localparam int NCH = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [11:0]       reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NCH-1:0]    done_evt = '0;
  logic              err_evt = 1'b0;
  logic [5:0]        err_chan = '0;
  logic [15:0]       err_cause = '0;
  logic [NCH-1:0]    hwreq_in = '0;
  logic [NCH-1:0]    req_en;
  logic [NCH-1:0]    start_pulse;
  logic [NCH*8-1:0]  chan_prio;
  logic              ctrl_clkgate, rr_group, rr_chan, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dmareg_bank #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_evt(done_evt),
    .err_evt(err_evt), .err_chan(err_chan), .err_cause(err_cause),
    .hwreq_in(hwreq_in), .req_en(req_en), .start_pulse(start_pulse),
    .chan_prio(chan_prio), .ctrl_clkgate(ctrl_clkgate), .rr_group(rr_group),
    .rr_chan(rr_chan), .irq(irq)
  );

  typedef struct packed {
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{12'h040, 32'd5,         12'h00C, 32'h0000_0020, 8'd3},  // R3 set req ch5
    '{12'h040, 32'd40,        12'h008, 32'h0000_0100, 8'd3},  // R3 set req ch40, high word
    '{12'h044, 32'd5,         12'h00C, 32'h0000_0000, 8'd3},  // R3 clear req ch5
    '{12'h040, 32'd64,        12'h008, 32'h0000_0100, 8'd4},  // R4 channel 64 ignored
    '{12'h040, 32'd200,       12'h00C, 32'h0000_0000, 8'd4},  // R4 channel 200 ignored
    '{12'h048, 32'd63,        12'h010, 32'h8000_0000, 8'd3},  // R3 set eei ch63
    '{12'h04C, 32'd63,        12'h010, 32'h0000_0000, 8'd3},  // R3 clear eei ch63
    '{12'h000, 32'hFFFF_FFFF, 12'h000, 32'h8000_000C, 8'd11}, // R11 control mask
    '{12'h104, 32'h4433_2211, 12'h104, 32'h4433_2211, 8'd12}, // R12 priority word 1
    '{12'h00C, 32'h0000_F00F, 12'h00C, 32'h0000_F00F, 8'd2},  // R2 word write low
    '{12'h00C, 32'h0000_0000, 12'h00C, 32'h0000_0000, 8'd2},  // R2 word write low clear
    '{12'h008, 32'h0000_0000, 12'h008, 32'h0000_0000, 8'd2}   // R2 word write high clear
  };

  task automatic chk(input int rq, input logic [31:0] got, input logic [31:0] ex);
    n_chk++;
    if (got !== ex) begin
      n_bad++;
      $display("FAIL R%0d got %h expected %h", rq, got, ex);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int rq, input logic [11:0] a, input logic [31:0] ex);
    reg_addr = a;
    #0.5;
    chk(rq, reg_rdata, ex);
  endtask

  task automatic err_pulse(input logic [5:0] ch, input logic [15:0] cause);
    @(negedge clk);
    err_evt = 1'b1; err_chan = ch; err_cause = cause;
    @(negedge clk);
    err_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1, 12'h000, 32'h0);
    rd(1, 12'h004, 32'h0);
    rd(1, 12'h024, 32'h0);
    rd(1, 12'h00C, 32'h0);
    chk(1, {31'h0, irq}, 32'h0);
    chk(1, 32'(start_pulse != '0), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(TBL[i].wa, TBL[i].wd);
      rd(int'(TBL[i].rq), TBL[i].ra, TBL[i].ex);
    end
    // R11 control outputs
    chk(11, {29'h0, ctrl_clkgate, rr_group, rr_chan}, 32'h7);
    // R12 priority byte of channel 5 on the output
    chk(12, 32'(chan_prio[5*8 +: 8]), 32'h22);

    // R5 completion sets pending and done; R9 irq
    @(negedge clk); done_evt = '0; done_evt[3] = 1'b1; done_evt[35] = 1'b1;
    @(negedge clk); done_evt = '0;
    rd(5, 12'h024, 32'h8);
    rd(5, 12'h020, 32'h8);
    rd(5, 12'h03C, 32'h8);
    chk(9, {31'h0, irq}, 32'h1);
    wr(12'h050, 32'd3);                 // R3 clear-int ch3 only
    rd(3, 12'h024, 32'h0);
    rd(3, 12'h020, 32'h8);
    wr(12'h020, 32'hFFFF_FFFF);          // R6 all ones clears word
    rd(6, 12'h020, 32'h0);
    chk(9, {31'h0, irq}, 32'h0);
    wr(12'h05C, 32'd3);                  // R3 clear done ch3
    rd(3, 12'h03C, 32'h0);
    rd(5, 12'h038, 32'h8);

    // R6 partial write-one-to-clear
    @(negedge clk); done_evt = '0; done_evt[2:0] = 3'b111;
    @(negedge clk); done_evt = '0;
    wr(12'h024, 32'h2);
    rd(6, 12'h024, 32'h5);
    wr(12'h024, 32'hFFFF_FFFF);
    rd(6, 12'h024, 32'h0);

    // R7 error capture, R9 masked irq
    err_pulse(6'd10, 16'hFFFF);
    rd(7, 12'h004, 32'h8000_CAFF);
    rd(7, 12'h02C, 32'h0000_0400);
    chk(9, {31'h0, irq}, 32'h0);
    wr(12'h048, 32'd10);
    chk(9, {31'h0, irq}, 32'h1);

    // R8 latch hold and release
    err_pulse(6'd20, 16'h0002);
    rd(8, 12'h004, 32'h8000_CAFF);
    rd(7, 12'h02C, 32'h0010_0400);
    wr(12'h054, 32'd20);
    rd(8, 12'h004, 32'h8000_CAFF);
    wr(12'h054, 32'd10);
    rd(8, 12'h004, 32'h0);
    chk(9, {31'h0, irq}, 32'h0);
    err_pulse(6'd33, 16'h0001);
    rd(7, 12'h004, 32'h8000_2101);
    rd(7, 12'h028, 32'h0000_0002);
    wr(12'h028, 32'h0000_0002);          // R8 release by word write
    rd(8, 12'h004, 32'h0);

    // R8 release and new error in the same cycle
    err_pulse(6'd10, 16'h0080);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h054; reg_wdata = 32'd10;
    err_evt = 1'b1; err_chan = 6'd5; err_cause = 16'h4000;
    @(negedge clk);
    reg_wr = 1'b0; err_evt = 1'b0;
    rd(8, 12'h004, 32'h8000_4500);
    wr(12'h02C, 32'hFFFF_FFFF);

    // R13 completion and clear-int of the same channel together
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h050; reg_wdata = 32'd7;
    done_evt = '0; done_evt[7] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; done_evt = '0;
    rd(13, 12'h024, 32'h80);

    // R10 start pulse lasts one cycle
    wr(12'h058, 32'd12);
    chk(10, 32'(start_pulse[12]), 32'h1);
    chk(10, 32'($countones(start_pulse)), 32'h1);
    @(negedge clk);
    chk(10, 32'(start_pulse != '0), 32'h0);

    // R14 hardware request status
    hwreq_in = 64'h8000_0001_0000_0003;
    rd(14, 12'h034, 32'h0000_0003);
    rd(14, 12'h030, 32'h8000_0001);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule